// File: doc/BRIEF.md
# Packed Instruction Register File Expander

This block sits between the fetch latch and the decode stage of a simple 32-bit in-order pipeline. Each fetched word is classified as plain, loosely packed or tightly packed. A plain word goes to the decoder unchanged. A packed word is expanded into a sequence of full 32-bit instructions, issued one per cycle. The instructions come from a windowed instruction register file and, where a parameter is encoded, from a small immediate table that overrides the low immediate bits of one instruction.

A tightly packed word carries up to five 5-bit references into the active window. A loosely packed word is an ordinary instruction with an 11-bit immediate. It carries one extra reference, and the referenced instruction issues right after the host. While a pack drains, fetch-ready stays low. The fetch of the following word can therefore continue upstream, which hides a cache miss behind the pack. A single write port fills the register file and the immediate table, and also sets the window pointer.

Top module: `pack_expander`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and the window pointer selects window 0.
- R2: A word with bit 31 clear is a plain word. It is presented on out_insn unchanged in the cycle after it is accepted, as a single instruction.
- R3: A word whose bits [31:26] equal the tight opcode (default 6'b111011) is a tightly packed word. Its references sit at bits [25:21], [20:16], [15:11], [10:6] and [4:0]. Each reference issues, in that order, the register-file entry of the latched window, one per cycle. in_ready stays low until the last one issues.
- R4: A reference value of 0 ends a pack. That slot and all later slots issue nothing. A tight word whose first reference is 0 issues no instruction at all.
- R5: When bit 5 of a tight word is 1, a pack has at most four references. Bits [4:0] then index the 32-entry immediate table, and the selected 16-bit value replaces bits [15:0] of the fourth instruction.
- R6: A word with bit 31 set and a non-tight opcode is loosely packed. First {word[31:16], five copies of word[15], word[15:5]} issues, then the register-file entry named by bits [4:0]. A reference of 0 issues the host only.
- R7: A window-pointer write (wr_target 2, value in wr_data[1:0]) applies to words accepted after the write cycle and never to a pack already accepted. The register file is addressed as {window, index} with wr_target 0, and the immediate table with wr_target 1.
- R8: While out_valid is high and out_ready is low, out_insn holds and no new word is accepted.
- R9: in_ready is high whenever no instruction is pending, and also in the cycle the final instruction of a pack is taken, so words can follow back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched word available |
| in_ready | output | 1 | Expander accepts a fetched word |
| in_word | input | 32 | Fetched word |
| out_valid | output | 1 | Instruction available to the decoder |
| out_ready | input | 1 | Decoder takes the instruction |
| out_insn | output | 32 | Expanded instruction |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 2 | 0 register file, 1 immediate table, 2 window pointer |
| wr_addr | input | 7 | {window, index} for the register file; low 5 bits for the immediate table |
| wr_data | input | 32 | Write data |

## Verification
The hardest states to reach from the ports are a window-pointer write that lands while a pack drains, and a decoder stall that arrives at the very slot where a pack ends. The stall case decides whether the next word may enter. The stimulus holds each fetched word valid until it is taken. It writes the window while a five-slot pack is partway through, and it runs a block of mixed words under a periodic out_ready pattern so stalls fall on first, middle and final slots. A reference model expands each accepted word into a queue and compares every cycle.

// File: rtl/pack_exp_pkg.sv
package pack_exp_pkg;

   typedef enum logic [1:0] {
      KIND_PLAIN = 2'd0,
      KIND_LOOSE = 2'd1,
      KIND_TIGHT = 2'd2
   } word_kind_t;

   typedef enum logic [1:0] {
      WT_IRF = 2'd0,
      WT_IMM = 2'd1,
      WT_WIN = 2'd2
   } wr_target_t;

   localparam int SLOT_COUNT = 5;
   localparam int SLOT_W     = 3;

   function automatic word_kind_t classify(input logic [31:0] w, input logic [5:0] tight_op);
      if (w[31:26] == tight_op) return KIND_TIGHT;
      else if (w[31])           return KIND_LOOSE;
      else                      return KIND_PLAIN;
   endfunction

endpackage

// File: rtl/irf_store.sv
module irf_store #(
   parameter int WORD_W = 32,
   parameter int REF_W  = 5,
   parameter int WIN_N  = 4,
   localparam int WIN_W  = $clog2(WIN_N),
   localparam int DEPTH  = 1 << REF_W,
   localparam int ADDR_W = WIN_W + REF_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [WIN_W-1:0]  rwin,
   input  logic [REF_W-1:0]  ridx,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] bank_out [WIN_N];

   for (genvar w = 0; w < WIN_N; w++) begin : g_bank
      logic [WORD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && waddr[ADDR_W-1:REF_W] == WIN_W'(w))
            mem[waddr[REF_W-1:0]] <= wdata;
      end
      assign bank_out[w] = mem[ridx];
   end

   assign rdata = bank_out[rwin];

endmodule

// File: rtl/imm_table.sv
module imm_table #(
   parameter int REF_W = 5,
   parameter int IMM_W = 16,
   localparam int DEPTH = 1 << REF_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [REF_W-1:0] waddr,
   input  logic [IMM_W-1:0] wdata,
   input  logic [REF_W-1:0] ridx,
   output logic [IMM_W-1:0] rdata
);

   logic [IMM_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[ridx];

endmodule

// File: rtl/pack_slicer.sv
module pack_slicer
   import pack_exp_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int REF_W  = 5
) (
   input  logic [WORD_W-1:0] word,
   input  word_kind_t        kind,
   input  logic [SLOT_W-1:0] slot,
   output logic [REF_W-1:0]  cur_ref,
   output logic [REF_W-1:0]  nxt_ref,
   output logic              slot_final,
   output logic              use_param,
   output logic [REF_W-1:0]  param_idx,
   output logic [WORD_W-1:0] host
);

   logic [REF_W-1:0] refs [SLOT_COUNT];
   logic             flag;

   for (genvar i = 0; i < SLOT_COUNT - 1; i++) begin : g_ref
      assign refs[i] = word[WORD_W-7-REF_W*i -: REF_W];
   end
   assign refs[SLOT_COUNT-1] = word[REF_W-1:0];
   assign flag               = word[REF_W];

   always_comb begin
      cur_ref    = '0;
      nxt_ref    = '0;
      slot_final = 1'b1;
      use_param  = 1'b0;
      param_idx  = refs[SLOT_COUNT-1];
      host       = {word[WORD_W-1:16], {5{word[15]}}, word[15:5]};
      case (kind)
         KIND_TIGHT: begin
            for (int i = 0; i < SLOT_COUNT; i++)
               if (slot == SLOT_W'(i)) cur_ref = refs[i];
            for (int i = 0; i < SLOT_COUNT - 1; i++)
               if (slot == SLOT_W'(i)) nxt_ref = refs[i+1];
            slot_final = flag ? (slot == SLOT_W'(SLOT_COUNT - 2))
                              : (slot == SLOT_W'(SLOT_COUNT - 1));
            use_param  = flag && (slot == SLOT_W'(SLOT_COUNT - 2));
         end
         KIND_LOOSE: begin
            cur_ref    = word[REF_W-1:0];
            nxt_ref    = (slot == '0) ? word[REF_W-1:0] : '0;
            slot_final = (slot != '0);
         end
         default: slot_final = 1'b1;
      endcase
   end

endmodule

// File: rtl/pack_expander.sv
module pack_expander
   import pack_exp_pkg::*;
#(
   parameter int           WORD_W   = 32,
   parameter int           REF_W    = 5,
   parameter int           WIN_N    = 4,
   parameter int           IMM_W    = 16,
   parameter logic [5:0]   TIGHT_OP = 6'b111011,
   localparam int WIN_W  = $clog2(WIN_N),
   localparam int ADDR_W = WIN_W + REF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_insn,
   input  logic              wr_en,
   input  logic [1:0]        wr_target,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data
);

   if (WORD_W != 32) begin : g_bad_word
      $error("pack_expander: packed formats need a 32-bit word");
   end
   if (REF_W != 5) begin : g_bad_ref
      $error("pack_expander: reference fields are 5 bits wide");
   end
   if (WIN_N < 2 || (WIN_N & (WIN_N - 1)) != 0) begin : g_bad_win
      $error("pack_expander: window count must be a power of two, at least 2");
   end
   if (IMM_W < 1 || IMM_W > 16) begin : g_bad_imm
      $error("pack_expander: immediate width must be 1..16");
   end

   logic              busy;
   logic [WORD_W-1:0] word_q;
   word_kind_t        kind_q;
   logic [WIN_W-1:0]  win_q;
   logic [WIN_W-1:0]  win_reg;
   logic [SLOT_W-1:0] slot_q;

   logic [REF_W-1:0]  cur_ref, nxt_ref, param_idx;
   logic              slot_final, use_param;
   logic [WORD_W-1:0] host_insn, irf_rd;
   logic [IMM_W-1:0]  imm_rd;
   logic              fire, last, take;
   word_kind_t        kind_in;

   pack_slicer #(.WORD_W(WORD_W), .REF_W(REF_W)) u_slicer (
      .word(word_q), .kind(kind_q), .slot(slot_q),
      .cur_ref(cur_ref), .nxt_ref(nxt_ref), .slot_final(slot_final),
      .use_param(use_param), .param_idx(param_idx), .host(host_insn)
   );

   irf_store #(.WORD_W(WORD_W), .REF_W(REF_W), .WIN_N(WIN_N)) u_irf (
      .clk(clk),
      .we(wr_en && wr_target == WT_IRF),
      .waddr(wr_addr), .wdata(wr_data),
      .rwin(win_q), .ridx(cur_ref), .rdata(irf_rd)
   );

   imm_table #(.REF_W(REF_W), .IMM_W(IMM_W)) u_imm (
      .clk(clk),
      .we(wr_en && wr_target == WT_IMM),
      .waddr(wr_addr[REF_W-1:0]), .wdata(wr_data[IMM_W-1:0]),
      .ridx(param_idx), .rdata(imm_rd)
   );

   assign kind_in   = classify(in_word, TIGHT_OP);
   assign out_valid = busy;
   assign fire      = busy && out_ready;
   assign last      = slot_final || (nxt_ref == '0);
   assign in_ready  = !busy || (fire && last);
   assign take      = in_valid && in_ready;

   always_comb begin
      if (kind_q == KIND_PLAIN)
         out_insn = word_q;
      else if (kind_q == KIND_LOOSE && slot_q == '0)
         out_insn = host_insn;
      else begin
         out_insn = irf_rd;
         if (use_param) out_insn[IMM_W-1:0] = imm_rd;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy    <= 1'b0;
         word_q  <= '0;
         kind_q  <= KIND_PLAIN;
         win_q   <= '0;
         win_reg <= '0;
         slot_q  <= '0;
      end else begin
         if (wr_en && wr_target == WT_WIN)
            win_reg <= wr_data[WIN_W-1:0];
         if (take) begin
            word_q <= in_word;
            kind_q <= kind_in;
            win_q  <= win_reg;
            slot_q <= '0;
            busy   <= !(kind_in == KIND_TIGHT && in_word[WORD_W-7 -: REF_W] == '0);
         end else if (fire) begin
            if (last) busy   <= 1'b0;
            else      slot_q <= slot_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/pack_expander_chk.sv
module pack_expander_chk #(
   parameter int         WORD_W   = 32,
   parameter logic [5:0] TIGHT_OP = 6'b111011
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic [WORD_W-1:0] in_word,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_insn,
   input logic              wr_en
);

   // R2
   plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && !in_word[WORD_W-1]) |=>
      (out_valid && out_insn == $past(in_word)));

   // R4
   empty_pack_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_word[WORD_W-1 -: 6] == TIGHT_OP &&
       in_word[WORD_W-7 -: 5] == 5'd0) |=> !out_valid);

   // R3
   drain_block_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready && !wr_en) |=> (out_valid && $stable(out_insn)));

   // R9
   idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

endmodule

bind pack_expander pack_expander_chk #(.WORD_W(WORD_W), .TIGHT_OP(TIGHT_OP)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
   .out_insn(out_insn), .wr_en(wr_en)
);

// File: tb/pack_expander_test.sv
module pack_expander_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] TOP = 6'b111011;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_insn;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_target = '0;
   logic [6:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;

   pack_expander uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
      .out_insn(out_insn), .wr_en(wr_en), .wr_target(wr_target),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;

   logic [31:0] m_irf [128];
   logic [15:0] m_imm [32];
   int          m_win = 0;
   logic [31:0] q [$];

   logic        d_valid = 0, d_ordy = 1, d_wen = 0;
   logic [31:0] d_word = '0, d_wdata = '0;
   logic [1:0]  d_wtgt = '0;
   logic [6:0]  d_waddr = '0;
   bit          stall_mode = 0;
   int          cyc = 0;
   bit          took;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic void expand(logic [31:0] w);
      if (w[31:26] == TOP) begin
         int n = w[5] ? 4 : 5;
         for (int i = 0; i < n; i++) begin
            logic [4:0] r = (i < 4) ? w[25-5*i -: 5] : w[4:0];
            logic [31:0] ins;
            if (r == 0) break;
            ins = m_irf[m_win*32 + int'(r)];
            if (w[5] && i == 3) ins[15:0] = m_imm[w[4:0]];
            q.push_back(ins);
         end
      end else if (w[31]) begin
         q.push_back({w[31:16], {5{w[15]}}, w[15:5]});
         if (w[4:0] != 0) q.push_back(m_irf[m_win*32 + int'(w[4:0])]);
      end else begin
         q.push_back(w);
      end
   endfunction

   task automatic tick(string req);
      logic exp_ready;
      @(negedge clk);
      cyc++;
      if (stall_mode) d_ordy = (cyc % 3) != 0;
      in_valid = d_valid; in_word = d_word; out_ready = d_ordy;
      wr_en = d_wen; wr_target = d_wtgt; wr_addr = d_waddr; wr_data = d_wdata;
      #1;
      exp_ready = (q.size() == 0) || (q.size() == 1 && d_ordy);
      check(req, "out_valid", 32'(out_valid), 32'(q.size() != 0));
      check(req, "in_ready", 32'(in_ready), 32'(exp_ready));
      if (q.size() != 0) check(req, "out_insn", out_insn, q[0]);
      if (q.size() != 0 && d_ordy) void'(q.pop_front());
      took = d_valid && exp_ready;
      if (took) expand(d_word);
      if (d_wen) begin
         if (d_wtgt == 2'd0) m_irf[d_waddr] = d_wdata;
         else if (d_wtgt == 2'd1) m_imm[d_waddr[4:0]] = d_wdata[15:0];
         else if (d_wtgt == 2'd2) m_win = int'(d_wdata[1:0]);
      end
   endtask

   task automatic send(logic [31:0] w, string req);
      d_valid = 1; d_word = w;
      do tick(req); while (!took);
      d_valid = 0;
   endtask

   task automatic idle(int n, string req);
      for (int i = 0; i < n; i++) tick(req);
   endtask

   task automatic wr(logic [1:0] t, logic [6:0] a, logic [31:0] d, string req);
      d_wen = 1; d_wtgt = t; d_waddr = a; d_wdata = d;
      tick(req);
      d_wen = 0;
   endtask

   function automatic logic [31:0] tight(logic [4:0] a, b, c, d, logic f, logic [4:0] e);
      return {TOP, a, b, c, d, f, e};
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      idle(2, "R1");
      // R7: load storage through the write port
      for (int w = 0; w < 4; w++)
         for (int i = 1; i < 32; i++)
            wr(2'd0, 7'(w*32 + i),
               {4'hC, 4'(w), 8'(i*7+3), 16'(w*4099 + i*613 + 32'h8001)}, "R7");
      for (int k = 0; k < 32; k++) wr(2'd1, 7'(k), 32'(16'(k*2731) ^ 16'h5A5A), "R5");
      // R1: window 0 active after reset
      send(tight(5'd1, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0), "R1");
      idle(2, "R1");
      // R2: plain words
      send(32'h2149_0005, "R2"); idle(2, "R2");
      send(32'h0000_001F, "R2"); idle(1, "R2");
      // R3: full five-reference pack
      send(tight(5'd3, 5'd9, 5'd17, 5'd30, 1'b0, 5'd31), "R3");
      idle(6, "R3");
      // R4: zero in third slot, then empty pack
      send(tight(5'd4, 5'd5, 5'd0, 5'd6, 1'b0, 5'd7), "R4");
      idle(4, "R4");
      send(tight(5'd0, 5'd5, 5'd6, 5'd7, 1'b0, 5'd8), "R4");
      idle(2, "R4");
      // R5: parameter replaces the fourth instruction's immediate
      send(tight(5'd2, 5'd11, 5'd12, 5'd13, 1'b1, 5'd19), "R5");
      idle(5, "R5");
      send(tight(5'd2, 5'd0, 5'd12, 5'd13, 1'b1, 5'd19), "R5");
      idle(2, "R5");
      // R6: loose with negative 11-bit immediate, then reference 0
      send({6'b100011, 5'd3, 5'd7, 11'h4F5, 5'd21}, "R6"); idle(3, "R6");
      send({6'b101011, 5'd1, 5'd2, 11'h0A3, 5'd0}, "R6"); idle(2, "R6");
      // R7: window write during a pack affects only the next word
      send(tight(5'd1, 5'd2, 5'd3, 5'd4, 1'b0, 5'd5), "R7");
      wr(2'd2, 7'd0, 32'd2, "R7");
      idle(5, "R7");
      send(tight(5'd1, 5'd2, 5'd3, 5'd4, 1'b0, 5'd5), "R7");
      idle(6, "R7");
      send({6'b100001, 10'h155, 11'h321, 5'd9}, "R7"); idle(3, "R7");
      wr(2'd2, 7'd0, 32'd3, "R7");
      send(tight(5'd8, 5'd16, 5'd24, 5'd0, 1'b0, 5'd1), "R7"); idle(4, "R7");
      // R8: stalls landing on various slots
      stall_mode = 1;
      for (int r = 0; r < 4; r++) begin
         send(tight(5'(r+1), 5'(r+10), 5'(r+20), 5'(r+25), r[0], 5'(r+3)), "R8");
         send(32'h1234_5678 + 32'(r), "R8");
         send({6'b110001, 5'(r), 5'd4, 11'(r*300), 5'(r+6)}, "R8");
         send(tight(5'(r+2), 5'd0, 5'd1, 5'd1, 1'b0, 5'd1), "R8");
      end
      idle(8, "R8");
      stall_mode = 0; d_ordy = 1;
      // R9: back-to-back words
      send(32'h0ABC_0001, "R9");
      send(32'h0ABC_0002, "R9");
      send(tight(5'd5, 5'd6, 5'd0, 5'd0, 1'b0, 5'd0), "R9");
      send(32'h0ABC_0003, "R9");
      idle(3, "R9");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule